// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a single-slave SPI master for serial flash, mode 0 only. Software or a sequencer loads a command word and a 32-bit data word through a simple register write port. It then launches a transfer by writing a control word that gives two counts. The first is a combined transmit byte count, which covers the opcode, the address bytes and the payload bytes. The second is a separate receive byte count. The engine lowers chip select, clocks out the transmit bytes, clocks in the response bytes, and raises chip select again.

The command word holds the opcode in bits 7:0 and the flash address in the bits above it. Transmission walks the command word from its lowest byte upward and then continues into the data word, lowest byte first. Response bytes are written back into the data word little-endian. A busy output covers the whole transfer, and a one-cycle completion pulse marks its end. Each SCLK half period lasts `HALF_DIV` system clocks.

Top module: `spi_flash_cmd_engine`

## Requirements
- R1: After reset, chip select is high, SCLK and MOSI are low, busy and done are low, and the data word reads zero.
- R2: A control write (select 2) with bit 16 set, a nonzero transmit count in bits 3:0 and a receive count in bits 10:8, made while idle, raises busy and lowers chip select in the next cycle.
- R3: A start with a transmit count of 0 is ignored: busy stays low and chip select stays high.
- R4: Transmit byte n is command-word byte n for n < 4 and data-word byte n-4 for n >= 4. Byte 0 is the opcode at bits 7:0. Bits go out most significant first, and MOSI is low outside the transmit bits.
- R5: SCLK idles low and its first rising edge comes `HALF_DIV` clocks after chip select falls. MOSI changes only on falling edges, MISO is sampled on rising edges, and exactly 8×(transmit + receive) rising edges occur per transfer.
- R6: Chip select stays low without a break through the transmit and receive phases. It rises `HALF_DIV` clocks after the last falling SCLK edge.
- R7: Received byte r, assembled most significant bit first, lands in data-word bits 8r+7:8r. Data-word bytes at or above the receive count keep their previous value.
- R8: Busy stays high from the cycle after launch until the cycle in which chip select rises. In that cycle done pulses for exactly one cycle and busy is already low.
- R9: While busy, writes to the command word, the data word and the control word, including a new start, have no effect.
- R10: A transmit count above 8 acts as 8, and a receive count above 4 acts as 4.
- R11: A transmit count of 1 with a receive count of 0 sends the opcode alone: 8 SCLK cycles, and busy lasts (2×8+1)×`HALF_DIV` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 command word, 1 data word, 2 control |
| reg_wdata | input | 32 | Write data |
| data_q | output | 8×DATA_BYTES | Current data word, including received bytes |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A wrong bit index or byte pointer inside the sequencer puts the wrong value on MOSI, and it does so in the very half period where the bad index is first used. A miscomputed end-of-transfer bit shows up as a chip select window, busy window or SCLK edge count that is wrong by at least 2×`HALF_DIV` clocks. Faults in receive placement or gating only appear in the data word once busy drops. For that reason the data word is compared on every idle cycle against an independently tracked image.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned CTRL_RX_LSB = 8;
  localparam int unsigned CTRL_GO_BIT = 16;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TRAIL = 2'd3
  } seq_state_e;
endpackage

// File: rtl/spi_eng_div.sv
module spi_eng_div #(
  parameter  int unsigned HALF_DIV = 2,
  localparam int unsigned CW       = $clog2(HALF_DIV) + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)               cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5: half periods are at least two clocks apart
  a_r5_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/spi_eng_regs.sv
module spi_eng_regs #(
  parameter  int unsigned CMD_BYTES  = 4,
  parameter  int unsigned DATA_BYTES = 4,
  localparam int unsigned CMD_W      = 8 * CMD_BYTES,
  localparam int unsigned DATA_W     = 8 * DATA_BYTES,
  localparam int unsigned IDX_W      = $clog2(DATA_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              wr_cmd,
  input  logic              wr_data,
  input  logic [31:0]       wdata,
  input  logic              rx_vld,
  input  logic [IDX_W-1:0]  rx_idx,
  input  logic [7:0]        rx_byte,
  output logic [CMD_W-1:0]  cmd_q,
  output logic [DATA_W-1:0] data_q
);
  logic [CMD_W-1:0]  cmd_d;
  logic [DATA_W-1:0] data_d;
  logic              cmd_en, data_en;

  assign cmd_en  = wr_cmd  && !busy;
  assign data_en = wr_data && !busy;

  always_comb begin
    cmd_d = cmd_q;
    if (cmd_en) cmd_d = wdata[CMD_W-1:0];
  end

  for (genvar g = 0; g < DATA_BYTES; g++) begin : g_byte
    always_comb begin
      data_d[8*g +: 8] = data_q[8*g +: 8];
      if (data_en)
        data_d[8*g +: 8] = wdata[8*g +: 8];
      else if (rx_vld && (rx_idx == IDX_W'(g)))
        data_d[8*g +: 8] = rx_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      cmd_q  <= cmd_d;
      data_q <= data_d;
    end
  end

  // R9: command word frozen during a transfer
  a_r9_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cmd_q));
  // R9: data word only moves by received bytes during a transfer
  a_r9_data_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rx_vld) |=> $stable(data_q));
endmodule

// File: rtl/spi_eng_seq.sv
module spi_eng_seq
  import spi_eng_pkg::*;
#(
  parameter  int unsigned CMD_BYTES  = 4,
  parameter  int unsigned DATA_BYTES = 4,
  localparam int unsigned TX_MAX     = CMD_BYTES + DATA_BYTES,
  localparam int unsigned TXC_W      = $clog2(TX_MAX + 1),
  localparam int unsigned RXC_W      = $clog2(DATA_BYTES + 1),
  localparam int unsigned IDX_W      = $clog2(DATA_BYTES),
  localparam int unsigned FRAME_W    = 8 * TX_MAX
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [TXC_W-1:0]   tx_req,
  input  logic [RXC_W-1:0]   rx_req,
  input  logic [FRAME_W-1:0] frame,
  input  logic               tick,
  input  logic               miso,
  output logic               busy,
  output logic               done,
  output logic               cs_n,
  output logic               sclk,
  output logic               mosi,
  output logic               rx_vld,
  output logic [IDX_W-1:0]   rx_idx,
  output logic [7:0]         rx_byte
);
  localparam int unsigned BIT_W = $clog2(8 * (TX_MAX + DATA_BYTES));
  localparam int unsigned EXT_W = 1 << BIT_W;

  seq_state_e         state_q, state_d;
  logic [BIT_W-1:0]   bidx_q, bidx_d, last_q, last_d, txb_q, txb_d;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic               cs_n_q, cs_n_d, sclk_q, sclk_d, mosi_q, mosi_d;
  logic               done_q, done_d, rxv_q, rxv_d;
  logic [6:0]         rsh_q, rsh_d;
  logic [IDX_W-1:0]   ridx_q, ridx_d;
  logic [7:0]         rbyte_q, rbyte_d;

  logic [TXC_W-1:0]   tx_eff;
  logic [RXC_W-1:0]   rx_eff;
  logic               launch, rise_ev, fall_ev, in_rx;
  logic [BIT_W-1:0]   bidx_nx, nx_pos, rx_off;
  logic [EXT_W-1:0]   frame_ext;
  logic               nx_mosi;

  assign tx_eff  = (tx_req > TXC_W'(TX_MAX))     ? TXC_W'(TX_MAX)     : tx_req;
  assign rx_eff  = (rx_req > RXC_W'(DATA_BYTES)) ? RXC_W'(DATA_BYTES) : rx_req;
  assign launch  = (state_q == ST_IDLE) && go && (tx_req != '0);
  assign rise_ev = tick && ((state_q == ST_LEAD) || ((state_q == ST_SHIFT) && !sclk_q));
  assign fall_ev = tick && (state_q == ST_SHIFT) && sclk_q;

  assign frame_ext = {{(EXT_W - FRAME_W){1'b0}}, frame_q};
  assign bidx_nx   = bidx_q + 1'b1;
  assign nx_pos    = {bidx_nx[BIT_W-1:3], ~bidx_nx[2:0]};
  assign nx_mosi   = (bidx_nx < txb_q) ? frame_ext[nx_pos] : 1'b0;
  assign in_rx     = (bidx_q >= txb_q);
  assign rx_off    = bidx_q - txb_q;

  always_comb begin
    state_d = state_q;
    bidx_d  = bidx_q;
    last_d  = last_q;
    txb_d   = txb_q;
    frame_d = frame_q;
    cs_n_d  = cs_n_q;
    sclk_d  = sclk_q;
    mosi_d  = mosi_q;
    rsh_d   = rsh_q;
    ridx_d  = ridx_q;
    rbyte_d = rbyte_q;
    done_d  = 1'b0;
    rxv_d   = 1'b0;

    if (launch) begin
      state_d = ST_LEAD;
      cs_n_d  = 1'b0;
      sclk_d  = 1'b0;
      bidx_d  = '0;
      frame_d = frame;
      txb_d   = BIT_W'({tx_eff, 3'b000});
      last_d  = BIT_W'({tx_eff, 3'b000}) + BIT_W'({rx_eff, 3'b000}) - BIT_W'(1);
      mosi_d  = frame[7];
    end else if (rise_ev) begin
      state_d = ST_SHIFT;
      sclk_d  = 1'b1;
      if (in_rx) begin
        rsh_d = {rsh_q[5:0], miso};
        if (bidx_q[2:0] == 3'd7) begin
          rxv_d   = 1'b1;
          rbyte_d = {rsh_q, miso};
          ridx_d  = IDX_W'(rx_off >> 3);
        end
      end
    end else if (fall_ev) begin
      sclk_d = 1'b0;
      if (bidx_q == last_q) begin
        state_d = ST_TRAIL;
        mosi_d  = 1'b0;
      end else begin
        bidx_d = bidx_nx;
        mosi_d = nx_mosi;
      end
    end else if (tick && (state_q == ST_TRAIL)) begin
      state_d = ST_IDLE;
      cs_n_d  = 1'b1;
      done_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bidx_q  <= '0;
      last_q  <= '0;
      txb_q   <= '0;
      frame_q <= '0;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b0;
      mosi_q  <= 1'b0;
      done_q  <= 1'b0;
      rxv_q   <= 1'b0;
      rsh_q   <= '0;
      ridx_q  <= '0;
      rbyte_q <= '0;
    end else begin
      state_q <= state_d;
      bidx_q  <= bidx_d;
      last_q  <= last_d;
      txb_q   <= txb_d;
      frame_q <= frame_d;
      cs_n_q  <= cs_n_d;
      sclk_q  <= sclk_d;
      mosi_q  <= mosi_d;
      done_q  <= done_d;
      rxv_q   <= rxv_d;
      rsh_q   <= rsh_d;
      ridx_q  <= ridx_d;
      rbyte_q <= rbyte_d;
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;
  assign cs_n    = cs_n_q;
  assign sclk    = sclk_q;
  assign mosi    = mosi_q;
  assign rx_vld  = rxv_q;
  assign rx_idx  = ridx_q;
  assign rx_byte = rbyte_q;

  // R6: chip select high whenever the sequencer is idle
  a_r6_cs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> cs_n_q);
  // R5: SCLK pulses only inside the chip select window
  a_r5_sclk_framed: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_q |-> !cs_n_q);
  // R5: MOSI holds while SCLK is high
  a_r5_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_q |-> $stable(mosi_q));
  // R8: done lasts one cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R8: done closes a busy window
  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy && $past(busy)));
  // R3: a zero transmit count never launches
  a_r3_zero_tx: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) && go && (tx_req == '0)) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/spi_flash_cmd_engine.sv
module spi_flash_cmd_engine
  import spi_eng_pkg::*;
#(
  parameter  int unsigned HALF_DIV   = 2,
  parameter  int unsigned CMD_BYTES  = 4,
  parameter  int unsigned DATA_BYTES = 4,
  localparam int unsigned DATA_W     = 8 * DATA_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [DATA_W-1:0] data_q,
  output logic              busy,
  output logic              done,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int unsigned TX_MAX = CMD_BYTES + DATA_BYTES;
  localparam int unsigned TXC_W  = $clog2(TX_MAX + 1);
  localparam int unsigned RXC_W  = $clog2(DATA_BYTES + 1);
  localparam int unsigned IDX_W  = $clog2(DATA_BYTES);
  localparam int unsigned CMD_W  = 8 * CMD_BYTES;

  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  logic              wr_cmd, wr_data, go, tick, rx_vld;
  logic [IDX_W-1:0]  rx_idx;
  logic [7:0]        rx_byte;
  logic [CMD_W-1:0]  cmd_w;
  logic [DATA_W-1:0] data_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  assign wr_cmd  = reg_wr && (reg_sel == SEL_CMD);
  assign wr_data = reg_wr && (reg_sel == SEL_DATA);
  assign go      = reg_wr && (reg_sel == SEL_CTRL) && reg_wdata[CTRL_GO_BIT];

  spi_eng_regs #(.CMD_BYTES(CMD_BYTES), .DATA_BYTES(DATA_BYTES)) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .busy    (busy),
    .wr_cmd  (wr_cmd),
    .wr_data (wr_data),
    .wdata   (reg_wdata),
    .rx_vld  (rx_vld),
    .rx_idx  (rx_idx),
    .rx_byte (rx_byte),
    .cmd_q   (cmd_w),
    .data_q  (data_w)
  );

  spi_eng_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_int_n),
    .run   (busy),
    .tick  (tick)
  );

  spi_eng_seq #(.CMD_BYTES(CMD_BYTES), .DATA_BYTES(DATA_BYTES)) u_seq (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .go      (go),
    .tx_req  (reg_wdata[TXC_W-1:0]),
    .rx_req  (reg_wdata[CTRL_RX_LSB +: RXC_W]),
    .frame   ({data_w, cmd_w}),
    .tick    (tick),
    .miso    (spi_miso),
    .busy    (busy),
    .done    (done),
    .cs_n    (spi_cs_n),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi),
    .rx_vld  (rx_vld),
    .rx_idx  (rx_idx),
    .rx_byte (rx_byte)
  );

  assign data_q = data_w;

  // R2: a launch drops chip select on the next edge
  a_r2_launch: assert property (@(posedge clk) disable iff (!rst_int_n)
    (go && !busy && (reg_wdata[TXC_W-1:0] != '0)) |=> (busy && !spi_cs_n));
endmodule

// File: tb/spi_flash_cmd_engine_test.sv
`timescale 1ns/1ps
module spi_flash_cmd_engine_test;
  localparam int H = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd3;
  logic [31:0] reg_wdata = '0;
  logic        spi_miso = 1'b0;
  logic [31:0] data_q;
  logic        busy, done, spi_cs_n, spi_sclk, spi_mosi;

  int checks = 0;
  int failures = 0;

  // reference model state
  int          k = -1;
  int          endk = 0;
  int          nbits = 0;
  int          txm = 0;
  int          rises = 0;
  logic        sclk_prev = 1'b0;
  logic [31:0] cmd_m = '0;
  logic [31:0] data_m = '0;
  logic [63:0] frame_m = '0;
  logic [31:0] rx_pat = '0;
  logic [31:0] rx_pat_m = '0;

  always #4 clk = ~clk;

  spi_flash_cmd_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .data_q(data_q), .busy(busy), .done(done),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison and model advance
  always @(negedge clk) begin
    if (rst_n) begin
      logic eb, ec, es, em, ed;
      int j, b, rb, t, r;
      eb = 1'b0; ec = 1'b1; es = 1'b0; em = 1'b0; ed = 1'b0;
      j = 0; b = 0;
      if (k >= 0 && k < endk) begin
        eb = 1'b1; ec = 1'b0;
        j = k / H;
        es = (j % 2 == 1) && (j < 2 * nbits);
        if (j < 2 * nbits) begin
          b = j / 2;
          if (b < 8 * txm) em = frame_m[(b / 8) * 8 + 7 - (b % 8)];
        end
      end else if (k == endk) begin
        ed = 1'b1;
      end
      chk({31'b0, busy}, {31'b0, eb}, "R8 busy");
      chk({31'b0, done}, {31'b0, ed}, "R8 done");
      chk({31'b0, spi_cs_n}, {31'b0, ec}, "R6 cs_n");
      chk({31'b0, spi_sclk}, {31'b0, es}, "R5 sclk");
      chk({31'b0, spi_mosi}, {31'b0, em}, "R4 mosi");
      if (!eb) chk(data_q, data_m, "R7 data");
      if (spi_sclk && !sclk_prev) rises++;
      sclk_prev = spi_sclk;
      if (k == endk && k >= 0) chk(rises, nbits, "R5 edge count");

      spi_miso = 1'b0;
      if (k >= 0 && k < endk && j < 2 * nbits && b >= 8 * txm) begin
        rb = b - 8 * txm;
        spi_miso = rx_pat_m[(rb / 8) * 8 + 7 - (rb % 8)];
      end

      if ((k < 0 || k == endk) && reg_wr) begin
        if (reg_sel == 2'd0) cmd_m = reg_wdata;
        if (reg_sel == 2'd1) data_m = reg_wdata;
      end
      t = reg_wdata[3:0];
      r = reg_wdata[10:8];
      if (t > 8) t = 8;
      if (r > 4) r = 4;
      if ((k < 0 || k == endk) && reg_wr && reg_sel == 2'd2 && reg_wdata[16] && t != 0) begin
        frame_m  = {data_m, cmd_m};
        rx_pat_m = rx_pat;
        txm      = t;
        nbits    = 8 * (t + r);
        endk     = (2 * nbits + 1) * H;
        rises    = 0;
        k        = 0;
        for (int i = 0; i < r; i++) data_m[8 * i +: 8] = rx_pat[8 * i +: 8];
      end else if (k >= 0 && k < endk) begin
        k++;
      end else begin
        k = -1;
      end
    end
  end

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_sel = 2'd3; reg_wdata = '0;
  endtask

  function automatic logic [31:0] ctl(input int t, input int r);
    return (32'd1 << 16) | (32'(r) << 8) | 32'(t);
  endfunction

  task automatic wait_idle(output int dur);
    dur = 0;
    while (busy) begin
      dur++;
      @(posedge clk); #1;
    end
  endtask

  task automatic run(input int t, input int r, input logic [31:0] pat, output int dur);
    rx_pat = pat;
    wr(2'd2, ctl(t, r));
    chk({30'b0, busy, spi_cs_n}, 32'b10, "R2 launch");
    wait_idle(dur);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int dur;
    logic [31:0] keep;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    chk({27'b0, spi_cs_n, spi_sclk, spi_mosi, busy, done}, 32'b10000, "R1 outputs");
    chk(data_q, 32'h0, "R1 data");

    // R11 opcode alone
    wr(2'd0, 32'h0000_0006);
    run(1, 0, 32'h0, dur);
    chk(dur, (2 * 8 + 1) * H, "R11 busy length");

    // R4 R7 read: opcode + 3 address bytes, 4 bytes back
    wr(2'd0, 32'h1234_5603);
    run(4, 4, 32'hA1B2_C3D4, dur);
    chk(data_q, 32'hA1B2_C3D4, "R7 read word");

    // R4 full transmit with payload
    wr(2'd1, 32'hDEAD_BEEF);
    wr(2'd0, 32'h00AB_CD02);
    run(8, 0, 32'h0, dur);
    chk(data_q, 32'hDEAD_BEEF, "R7 no rx keeps data");

    // R7 one byte back, upper bytes kept
    wr(2'd0, 32'h0000_0005);
    run(1, 1, 32'h0000_005A, dur);
    chk(data_q, 32'hDEAD_BE5A, "R7 partial rx");

    // R4 opcode + one command byte, two back
    wr(2'd0, 32'h0000_C39F);
    run(2, 2, 32'h0000_6B1E, dur);
    chk(data_q, 32'hDEAD_6B1E, "R7 two bytes");

    // R3 zero transmit count
    wr(2'd2, ctl(0, 2));
    repeat (3) @(posedge clk);
    #1;
    chk({30'b0, busy, spi_cs_n}, 32'b01, "R3 zero tx ignored");

    // R10 clamped counts
    wr(2'd1, 32'h0F1E_2D3C);
    wr(2'd0, 32'h4B5A_6978);
    rx_pat = 32'h8796_A5B4;
    wr(2'd2, 32'h0001_070F);
    wait_idle(dur);
    chk(dur, (2 * 96 + 1) * H, "R10 busy length");
    chk(data_q, 32'h8796_A5B4, "R10 rx clamp");

    // R9 writes while busy ignored
    keep = data_q;
    wr(2'd0, 32'h0000_55AA);
    wr(2'd2, ctl(2, 0));
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd1, 32'h1234_5678);
    wr(2'd2, ctl(8, 4));
    wait_idle(dur);
    chk(data_q, keep, "R9 data kept");
    run(2, 0, 32'h0, dur);
    chk(dur, (2 * 16 + 1) * H, "R9 stale start ignored");

    repeat (4) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule